// File: doc/BRIEF.md
# Cycle-Stealing DMA Bus Controller

This controller lets a DMA requester take the system bus away from an 8-bit CPU that has a 16-bit, memory-mapped address space. After a request is accepted, it moves a given number of bytes to consecutive addresses, starting at a given address. It drives the address and read/write lines only while the CPU has let go of them. It tells the CPU to release its data buffers through a separate data-bus enable.

Two ways of obtaining the bus are offered.

- **Halt mode.** The controller pulls an active-low halt request. It then waits until the CPU reports that the bus is free, which happens once the CPU has finished its current instruction. After that it streams the whole transfer in one go.
- **Steal mode.** The controller raises the tri-state control line. It lets the CPU's address and read/write drivers settle for a programmable number of cycles, then moves bytes.

The CPU keeps its registers in dynamic storage, so the tri-state line may never stay high longer than a programmable cap. A long steal transfer is therefore cut into bursts separated by rest cycles. Each new burst carries on at the next address with the remaining count.

Top module: `bus_steal_dma`

## Requirements
- R1: A synchronous active-high reset, even in the middle of a transfer, leaves haltN=1, tscOut=0, dbeOut=1, busDrive=0, doneOut=0 on the next cycle. Any pending request is discarded.
- R2: A request with xferCount equal to zero is ignored. All outputs keep their idle values, and doneOut stays 0.
- R3: In halt mode (stealMode=0), haltN goes low in the cycle after the request is accepted. busDrive stays 0 and dbeOut stays 1 until busAvail has been seen high at a clock edge.
- R4: In halt mode, busDrive is 1 and dbeOut is 0 from the cycle after busAvail is seen. One byte moves per cycle, with addrOut starting at startAddr and rising by one each cycle, until the count is used up.
- R5: In steal mode (stealMode=1), tscOut goes high and dbeOut goes low in the cycle after acceptance. busDrive stays 0 for SETTLE_CYC cycles (default 1) before the first access of every burst.
- R6: tscOut is never high for more than TSC_MAX_CYC consecutive cycles (default 4, settling included). When the cap is reached before the count is used up, tscOut is low for REST_CYC cycles (default 1). The next burst then continues at the following address.
- R7: doneOut is high for exactly one cycle, right after the final byte. In that same cycle haltN=1, tscOut=0, dbeOut=1 and busDrive=0.
- R8: The address is 16 bits wide and wraps from 0xFFFF to 0x0000 within a transfer.
- R9: While a transfer is in progress, changes on dmaReq, startAddr, xferCount, stealMode and xferWrite have no effect on it.
- R10: While busDrive=1, rwOut is 0 for a write transfer (xferWrite=1) and 1 for a read. rwOut is 1 whenever busDrive=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dmaReq | input | 1 | Transfer request, sampled while idle |
| stealMode | input | 1 | 1 = steal bursts via tri-state control, 0 = halt mode |
| xferWrite | input | 1 | 1 = write to memory, 0 = read |
| startAddr | input | 16 | First address of the transfer |
| xferCount | input | 16 | Number of bytes to move |
| busAvail | input | 1 | CPU reports it has released the bus |
| haltN | output | 1 | Active-low halt request to the CPU |
| tscOut | output | 1 | Tri-state control to the CPU |
| dbeOut | output | 1 | CPU data-bus enable (0 = CPU data buffers off) |
| busDrive | output | 1 | Enable for the controller's address and read/write drivers |
| addrOut | output | 16 | Transfer address (0 when not driving) |
| rwOut | output | 1 | Read/write line, 1 = read |
| doneOut | output | 1 | One-cycle pulse when the transfer completes |

## Verification
Steal transfers are run with lengths of exactly one burst, of several bursts with a short tail, and of a single byte. These runs separate an off-by-one in the burst cap from an error in how the rest phase keeps the count.

Halt transfers are run with short and long waits for busAvail, which shows whether the bus is ever driven early. A run starting just below 0xFFFF checks address wrap. Runs that change the inputs in mid-transfer, a zero-count request and a reset mid-burst cover the cases where a request must be dropped or ignored.

// File: rtl/bus_steal_dma_pkg.sv
package bus_steal_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HWAIT,
    S_BLK,
    S_SETTLE,
    S_STEAL,
    S_REST
  } dmaState_t;

  // strobes from control to the address/count datapath
  typedef struct packed {
    logic load;
    logic advance;
  } pathStrb_t;

endpackage

// File: rtl/bus_steal_path.sv
module bus_steal_path
  import bus_steal_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pathStrb_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xferCount,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastByte
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (strb.load) begin
      curAddr <= startAddr;
      remain  <= xferCount;
    end else if (strb.advance) begin
      curAddr <= curAddr + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  assign lastByte = (remain == CNT_W'(1));

  // R4: a byte is only moved while bytes remain
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    strb.advance |-> remain != '0);

  // R4 / R8: each moved byte steps the address by one, wrapping at the top
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && !strb.load) |=> curAddr == $past(curAddr) + 1'b1);

endmodule

// File: rtl/bus_steal_ctl.sv
module bus_steal_ctl
  import bus_steal_dma_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SETTLE_CYC  = 1,
  parameter int TSC_MAX_CYC = 4,
  parameter int REST_CYC    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dmaReq,
  input  logic             stealMode,
  input  logic             xferWrite,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             busAvail,
  input  logic             lastByte,
  output pathStrb_t        strb,
  output logic             haltN,
  output logic             tscOut,
  output logic             dbeOut,
  output logic             busDrive,
  output logic             rwOut,
  output logic             doneOut
);

  localparam int CW          = $clog2(TSC_MAX_CYC + REST_CYC + SETTLE_CYC + 1);
  localparam int STEAL_BYTES = TSC_MAX_CYC - SETTLE_CYC;

  dmaState_t state, nextState;
  logic [CW-1:0] cycCnt;
  logic          wrLatched;
  logic          accept;

  assign accept = dmaReq && (xferCount != '0);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   if (accept) nextState = stealMode ? S_SETTLE : S_HWAIT;
      S_HWAIT:  if (busAvail) nextState = S_BLK;
      S_BLK:    if (lastByte) nextState = S_IDLE;
      S_SETTLE: if (cycCnt == CW'(SETTLE_CYC - 1)) nextState = S_STEAL;
      S_STEAL: begin
        if (lastByte) nextState = S_IDLE;
        else if (cycCnt == CW'(STEAL_BYTES - 1)) nextState = S_REST;
      end
      S_REST:   if (cycCnt == CW'(REST_CYC - 1)) nextState = S_SETTLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cycCnt    <= '0;
      wrLatched <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      state   <= nextState;
      cycCnt  <= (nextState != state) ? '0 : cycCnt + 1'b1;
      doneOut <= busDrive && lastByte;
      if (state == S_IDLE && accept) wrLatched <= xferWrite;
    end
  end

  assign haltN        = !(state == S_HWAIT || state == S_BLK);
  assign tscOut       = (state == S_SETTLE || state == S_STEAL);
  assign busDrive     = (state == S_BLK || state == S_STEAL);
  assign dbeOut       = !(busDrive || state == S_SETTLE);
  assign rwOut        = busDrive ? !wrLatched : 1'b1;
  assign strb.load    = (state == S_IDLE) && accept;
  assign strb.advance = busDrive;

  // independent run-length counter on the tri-state line
  logic [CW-1:0] hiRun;
  always_ff @(posedge clk) begin
    if (rst || !tscOut) hiRun <= '0;
    else if (hiRun != '1) hiRun <= hiRun + 1'b1;
  end

  p_tsc_cap_r6: assert property (@(posedge clk) disable iff (rst)
    tscOut |-> hiRun < CW'(TSC_MAX_CYC));

  p_settle_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tscOut) |-> !busDrive);

  p_halt_wait_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(haltN) |-> (!busDrive && dbeOut));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> (haltN && !tscOut && dbeOut && !busDrive));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  p_rw_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busDrive |-> rwOut);

endmodule

// File: rtl/bus_steal_dma.sv
module bus_steal_dma
  import bus_steal_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SETTLE_CYC  = 1,
  parameter int TSC_MAX_CYC = 4,
  parameter int REST_CYC    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmaReq,
  input  logic              stealMode,
  input  logic              xferWrite,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic              busAvail,
  output logic              haltN,
  output logic              tscOut,
  output logic              dbeOut,
  output logic              busDrive,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rwOut,
  output logic              doneOut
);

  pathStrb_t         strb;
  logic [ADDR_W-1:0] curAddr;
  logic              lastByte;

  bus_steal_ctl #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC),
    .TSC_MAX_CYC(TSC_MAX_CYC), .REST_CYC(REST_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .dmaReq(dmaReq), .stealMode(stealMode),
    .xferWrite(xferWrite), .xferCount(xferCount), .busAvail(busAvail),
    .lastByte(lastByte), .strb(strb), .haltN(haltN), .tscOut(tscOut),
    .dbeOut(dbeOut), .busDrive(busDrive), .rwOut(rwOut), .doneOut(doneOut)
  );

  bus_steal_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rst(rst), .strb(strb), .startAddr(startAddr),
    .xferCount(xferCount), .curAddr(curAddr), .lastByte(lastByte)
  );

  assign addrOut = busDrive ? curAddr : '0;

endmodule

// File: tb/bus_steal_dma_bench.sv
module bus_steal_dma_bench;

  localparam int SETTLE = 1;
  localparam int TMAX   = 4;
  localparam int REST   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dmaReq = 1'b0, stealMode = 1'b0, xferWrite = 1'b0, busAvail = 1'b0;
  logic [15:0] startAddr = '0, xferCount = '0;
  logic haltN, tscOut, dbeOut, busDrive, rwOut, doneOut;
  logic [15:0] addrOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bus_steal_dma #(.SETTLE_CYC(SETTLE), .TSC_MAX_CYC(TMAX), .REST_CYC(REST)) u_bus_steal_dma (
    .clk(clk), .rst(rst), .dmaReq(dmaReq), .stealMode(stealMode),
    .xferWrite(xferWrite), .startAddr(startAddr), .xferCount(xferCount),
    .busAvail(busAvail), .haltN(haltN), .tscOut(tscOut), .dbeOut(dbeOut),
    .busDrive(busDrive), .addrOut(addrOut), .rwOut(rwOut), .doneOut(doneOut)
  );

  // vector order: haltN, tscOut, dbeOut, busDrive, rwOut, doneOut
  task automatic chkVec(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {haltN, tscOut, dbeOut, busDrive, rwOut, doneOut};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ctl actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chkAddr(string req, logic [15:0] exp);
    checks++;
    if (addrOut !== exp) begin
      failures++;
      $display("FAIL %s addr actual=%h expected=%h t=%0t", req, addrOut, exp, $time);
    end
  endtask

  task automatic startReq(logic [15:0] a, logic [15:0] n, logic steal, logic wr);
    @(negedge clk);
    dmaReq = 1'b1; startAddr = a; xferCount = n; stealMode = steal; xferWrite = wr;
    @(negedge clk);
    dmaReq = 1'b0;
    // R9: scramble the inputs while busy; the transfer must ignore them
    startAddr = ~a; xferCount = 16'd0; stealMode = ~steal; xferWrite = ~wr;
  endtask

  task automatic runSteal(logic [15:0] a, int n, logic wr, string req);
    logic [15:0] ea;
    int rem;
    int k;
    ea = a; rem = n;
    startReq(a, 16'(n), 1'b1, wr);
    while (rem > 0) begin
      for (int i = 0; i < SETTLE; i++) begin
        chkVec({req, " R5 settle"}, 6'b110010);
        @(negedge clk);
      end
      k = (rem < TMAX - SETTLE) ? rem : TMAX - SETTLE;
      for (int j = 0; j < k; j++) begin
        chkVec({req, " R6 R10 steal"}, {4'b1101, ~wr, 1'b0});
        chkAddr({req, " R6 R8 R9"}, ea);
        ea = ea + 16'd1;
        @(negedge clk);
      end
      rem -= k;
      if (rem > 0)
        for (int i = 0; i < REST; i++) begin
          chkVec({req, " R6 rest"}, 6'b101010);
          @(negedge clk);
        end
    end
    chkVec({req, " R7 done"}, 6'b101011);
    @(negedge clk);
    chkVec({req, " R7 pulse"}, 6'b101010);
  endtask

  task automatic runBlock(logic [15:0] a, int n, int waitCyc, logic wr, string req);
    logic [15:0] ea;
    ea = a;
    startReq(a, 16'(n), 1'b0, wr);
    for (int w = 0; w < waitCyc; w++) begin
      chkVec({req, " R3 wait"}, 6'b001010);
      if (w == waitCyc - 1) busAvail = 1'b1;
      @(negedge clk);
    end
    for (int j = 0; j < n; j++) begin
      chkVec({req, " R4 R10 block"}, {4'b0001, ~wr, 1'b0});
      chkAddr({req, " R4 R9"}, ea);
      ea = ea + 16'd1;
      @(negedge clk);
    end
    busAvail = 1'b0;
    chkVec({req, " R7 done"}, 6'b101011);
    @(negedge clk);
    chkVec({req, " R7 pulse"}, 6'b101010);
  endtask

  task automatic testReset();
    @(negedge clk);
    chkVec("R1 reset", 6'b101010);
    rst = 1'b0;
  endtask

  task automatic testZero();
    @(negedge clk);
    dmaReq = 1'b1; xferCount = 16'd0; stealMode = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chkVec("R2 zero count", 6'b101010);
    end
    dmaReq = 1'b0;
  endtask

  task automatic testMidReset();
    startReq(16'h1000, 16'd10, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chkVec("R1 mid reset", 6'b101010);
    rst = 1'b0;
    @(negedge clk);
    chkVec("R1 stays idle", 6'b101010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testZero();
    runSteal(16'h2000, 3, 1'b0, "one burst");
    runSteal(16'h3010, 7, 1'b1, "multi burst");
    runSteal(16'h4000, 1, 1'b0, "single byte");
    runSteal(16'hFFFE, 5, 1'b1, "R8 wrap steal");
    runBlock(16'h5000, 4, 1, 1'b1, "short wait");
    runBlock(16'hFFFD, 6, 5, 1'b0, "R8 wrap long wait");
    testMidReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule